// File: doc/BRIEF.md
# DDS Serial Command Register Interface

This block is the serial front end of a direct digital synthesizer. A host sends 16-bit command words over a SPI-style link. Each word is framed by its own low period of an active-low chip select and is shifted in most significant bit first. The upper four bits of a word are the command code, the next four a byte address, and the low eight a data byte. From these words the block builds two 32-bit frequency tuning words and four 12-bit phase offsets, and it keeps a small set of control flags. The synthesizer core reads all of these directly from the outputs.

Wide values are written in pieces. A staging command parks one byte in a holding latch. The commit command that follows writes the latched byte and its own byte together as a 16-bit half of the target register. Control words use the bits that overlap the command field. The sync/source family therefore spans codes 0x8 to 0xB, and the power family spans 0xC to 0xF. The frequency and phase selections can come either from the serial control bits or from external select pins, and the chosen words are presented registered on the active outputs.

The serial pins are sampled with the system clock after a synchronizer, so the serial clock must be several times slower than the system clock.

Top module: `dds_cmd_port`

## Requirements
- R1: After reset, sleep, reset and clear read 1. All frequency and phase registers, the holding byte, sync, select-source and both selections read 0.
- R2: A word is accepted only when exactly 16 rising serial clock edges occur while chip select is low. Bits are taken MSB first on the rising edge, and the word is acted on once chip select rises. A frame with fewer or more edges changes nothing.
- R3: Command 0x3 or 0x1 stores data bits 7:0 in a single shared holding byte. Command 0x2 at an address with bit 3 clear writes {holding byte, data byte} into frequency register addr[2], in bits 31:16 when addr[1]=1 and bits 15:0 when addr[1]=0. Address bit 0 is ignored.
- R4: Command 0x0 at an address with bit 3 set writes {holding byte bits 3:0, data byte} into phase register addr[2:1].
- R5: Command 0x2 with address bit 3 set, or command 0x0 with address bit 3 clear, changes no register.
- R6: Commands 0x6 and 0x7 set the frequency selection to word bit 11 and the phase selection to word bits 10:9.
- R7: Commands 0x8 to 0xB set sync to word bit 13 and select-source to word bit 12.
- R8: Commands 0xC to 0xF set sleep to word bit 13, reset to bit 12 and clear to bit 11.
- R9: Commands 0x4 and 0x5 change no output.
- R10: While select-source is 1, the selection outputs follow the external select pins. While it is 0, they follow the serially written selection bits.
- R11: The active frequency output equals the frequency register picked by the frequency selection output. The active phase output equals the phase register picked by the phase selection output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low, data taken on rising edge |
| spi_csn | input | 1 | Active-low word frame |
| spi_mosi | input | 1 | Serial data in, MSB first |
| ext_fsel | input | 1 | External frequency selection pin |
| ext_psel | input | 2 | External phase selection pins |
| freq_words_o | output | 64 | Frequency register 1 in 63:32, register 0 in 31:0 |
| phase_words_o | output | 48 | Phase register n in bits 12n+11:12n |
| fsel_o | output | 1 | Effective frequency selection |
| psel_o | output | 2 | Effective phase selection |
| active_freq_o | output | 32 | Selected frequency tuning word |
| active_phase_o | output | 12 | Selected phase offset |
| sync_o | output | 1 | Sync control flag |
| selsrc_o | output | 1 | Select-source flag (1 = external pins) |
| sleep_o | output | 1 | Sleep flag |
| reset_o | output | 1 | Core reset flag |
| clear_o | output | 1 | Clear flag |

## Verification
The bench sends frames of 12, 15, 17 and 18 clocks. A receiver that acts on any frame ending with a wrong count would corrupt registers here. It sends commit commands whose address is in the wrong half of the map and the unused codes 0x4 and 0x5. A loose decoder would overwrite a frequency or phase word on these. It also sends control words with codes 0x9 to 0xF, where the flag bits overlap the command field. A decoder that matched only 0x8 and 0xC would leave those flags stuck. Finally it toggles the external select pins with select-source both set and clear, which exposes a selection multiplexer that is inverted or ignores the source bit.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;

  localparam int CMD_W     = 4;
  localparam int ADDR_W    = 4;
  localparam int BYTE_W    = 8;
  localparam int CMDWORD_W = CMD_W + ADDR_W + BYTE_W;
  localparam int N_FREQ    = 2;
  localparam int N_PHASE   = 4;
  localparam int FREQ_W    = 32;
  localparam int HALF_W    = 2 * BYTE_W;
  localparam int PSEL_W    = $clog2(N_PHASE);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_STAGE,
    OP_FR_COMMIT,
    OP_PH_COMMIT,
    OP_SELECT,
    OP_SYNCSRC,
    OP_POWER
  } op_t;

  typedef struct packed {
    logic              fsel;
    logic [PSEL_W-1:0] psel;
    logic              sync;
    logic              selsrc;
    logic              sleep;
    logic              core_rst;
    logic              clr;
  } ctrl_t;

  function automatic op_t classify(input logic [CMD_W-1:0] code);
    op_t op;
    casez (code)
      4'b0000: op = OP_PH_COMMIT;
      4'b0001: op = OP_STAGE;
      4'b0010: op = OP_FR_COMMIT;
      4'b0011: op = OP_STAGE;
      4'b011?: op = OP_SELECT;
      4'b10??: op = OP_SYNCSRC;
      4'b11??: op = OP_POWER;
      default: op = OP_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/spi_word_rx.sv
module spi_word_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sy, csn_sy, mosi_sy;
  logic                   sclk_d, csn_d;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_W-1:0]      shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy <= '0;
      csn_sy  <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      csn_sy  <= {csn_sy[SYNC_STAGES-2:0], csn_i};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi_i};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
      csn_d   <= csn_sy[SYNC_STAGES-1];
    end
  end

  logic sclk_rise, frame_end, in_frame;
  assign sclk_rise = sclk_sy[SYNC_STAGES-1] & ~sclk_d;
  assign frame_end = csn_sy[SYNC_STAGES-1] & ~csn_d;
  assign in_frame  = ~csn_sy[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt      <= '0;
      shreg        <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (frame_end) begin
        word_valid_o <= (bit_cnt == CNT_FULL);
        word_o       <= shreg;
        bit_cnt      <= '0;
      end else if (in_frame && sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], mosi_sy[SYNC_STAGES-1]};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end else if (!in_frame) begin
        bit_cnt <= '0;
      end
    end
  end

  // R2: one accepted word per frame, never two in a row
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  // R2: a word is only accepted once the frame has closed
  p_after_frame_r2: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> csn_d);

endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
  import dds_cmd_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_valid_i,
  input  logic [CMDWORD_W-1:0] word_i,
  output logic [FREQ_W-1:0]    freq_q  [N_FREQ],
  output logic [PHASE_W-1:0]   phase_q [N_PHASE],
  output ctrl_t                ctrl_q
);

  localparam int PH_HI = PHASE_W - BYTE_W;
  localparam int HALVES = FREQ_W / HALF_W;

  op_t               op;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] data;
  logic [BYTE_W-1:0] hold_q;

  assign op   = classify(word_i[CMDWORD_W-1 -: CMD_W]);
  assign addr = word_i[BYTE_W +: ADDR_W];
  assign data = word_i[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      for (int f = 0; f < N_FREQ; f++) freq_q[f] <= '0;
      for (int p = 0; p < N_PHASE; p++) phase_q[p] <= '0;
    end else if (word_valid_i) begin
      if (op == OP_STAGE) hold_q <= data;
      for (int f = 0; f < N_FREQ; f++)
        for (int h = 0; h < HALVES; h++)
          if (op == OP_FR_COMMIT && !addr[3] && addr[2] == f[0] && addr[1] == h[0])
            freq_q[f][h*HALF_W +: HALF_W] <= {hold_q, data};
      for (int p = 0; p < N_PHASE; p++)
        if (op == OP_PH_COMMIT && addr[3] && addr[2:1] == p[1:0])
          phase_q[p] <= {hold_q[PH_HI-1:0], data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q          <= '0;
      ctrl_q.sleep    <= 1'b1;
      ctrl_q.core_rst <= 1'b1;
      ctrl_q.clr      <= 1'b1;
    end else if (word_valid_i) begin
      case (op)
        OP_SELECT: begin
          ctrl_q.fsel <= word_i[11];
          ctrl_q.psel <= word_i[10:9];
        end
        OP_SYNCSRC: begin
          ctrl_q.sync   <= word_i[13];
          ctrl_q.selsrc <= word_i[12];
        end
        OP_POWER: begin
          ctrl_q.sleep    <= word_i[13];
          ctrl_q.core_rst <= word_i[12];
          ctrl_q.clr      <= word_i[11];
        end
        default: ;
      endcase
    end
  end

  // R2: state moves only on an accepted word
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !word_valid_i |=> $stable(freq_q[0]) && $stable(freq_q[1]) &&
                      $stable(phase_q[0]) && $stable(phase_q[3]) && $stable(ctrl_q));

  // R9: unused codes leave every register alone
  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    word_valid_i && op == OP_NONE |=> $stable(freq_q[0]) && $stable(freq_q[1]) &&
                                      $stable(phase_q[1]) && $stable(ctrl_q));

  // R3: commit to the upper half of frequency register 0
  p_freq_commit_r3: assert property (@(posedge clk) disable iff (rst)
    word_valid_i && op == OP_FR_COMMIT && addr[3:1] == 3'b001 |=>
      freq_q[0][31:16] == $past({hold_q, data}));

  // R4: commit to phase register 0
  p_phase_commit_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid_i && op == OP_PH_COMMIT && addr[3:1] == 3'b100 |=>
      phase_q[0] == $past({hold_q[PH_HI-1:0], data}));

  // R5: a frequency commit aimed at the phase half changes no frequency word
  p_misaddr_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid_i && op == OP_FR_COMMIT && addr[3] |=>
      $stable(freq_q[0]) && $stable(freq_q[1]));

endmodule

// File: rtl/dds_sel_mux.sv
module dds_sel_mux
  import dds_cmd_pkg::*;
#(
  parameter int PHASE_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl_i,
  input  logic               ext_fsel_i,
  input  logic [PSEL_W-1:0]  ext_psel_i,
  input  logic [FREQ_W-1:0]  freq_i  [N_FREQ],
  input  logic [PHASE_W-1:0] phase_i [N_PHASE],
  output logic               fsel_o,
  output logic [PSEL_W-1:0]  psel_o,
  output logic [FREQ_W-1:0]  active_freq_o,
  output logic [PHASE_W-1:0] active_phase_o
);

  logic [SYNC_STAGES-1:0] fsel_sy;
  logic [PSEL_W-1:0]      psel_sy [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_sy <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) psel_sy[s] <= '0;
    end else begin
      fsel_sy    <= {fsel_sy[SYNC_STAGES-2:0], ext_fsel_i};
      psel_sy[0] <= ext_psel_i;
      for (int s = 1; s < SYNC_STAGES; s++) psel_sy[s] <= psel_sy[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_o         <= 1'b0;
      psel_o         <= '0;
      active_freq_o  <= '0;
      active_phase_o <= '0;
    end else begin
      fsel_o         <= ctrl_i.selsrc ? fsel_sy[SYNC_STAGES-1] : ctrl_i.fsel;
      psel_o         <= ctrl_i.selsrc ? psel_sy[SYNC_STAGES-1] : ctrl_i.psel;
      active_freq_o  <= freq_i[fsel_o];
      active_phase_o <= phase_i[psel_o];
    end
  end

  // R10: serial selection governs while the source bit is clear
  p_serial_sel_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i.selsrc |=> fsel_o == $past(ctrl_i.fsel) && psel_o == $past(ctrl_i.psel));

  // R11: the active frequency tracks the selected register
  p_active_freq_r11: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(fsel_o) |=> active_freq_o == $past(freq_i[fsel_o]));

endmodule

// File: rtl/dds_cmd_port.sv
module dds_cmd_port
  import dds_cmd_pkg::*;
#(
  parameter int PHASE_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       spi_sclk,
  input  logic                       spi_csn,
  input  logic                       spi_mosi,
  input  logic                       ext_fsel,
  input  logic [1:0]                 ext_psel,
  output logic [N_FREQ*FREQ_W-1:0]   freq_words_o,
  output logic [N_PHASE*PHASE_W-1:0] phase_words_o,
  output logic                       fsel_o,
  output logic [1:0]                 psel_o,
  output logic [FREQ_W-1:0]          active_freq_o,
  output logic [PHASE_W-1:0]         active_phase_o,
  output logic                       sync_o,
  output logic                       selsrc_o,
  output logic                       sleep_o,
  output logic                       reset_o,
  output logic                       clear_o
);

  logic                 word_valid;
  logic [CMDWORD_W-1:0] word;
  logic [FREQ_W-1:0]    freq_q  [N_FREQ];
  logic [PHASE_W-1:0]   phase_q [N_PHASE];
  ctrl_t                ctrl_q;

  spi_word_rx #(
    .WORD_W      (CMDWORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk          (clk),
    .rst          (rst),
    .sclk_i       (spi_sclk),
    .csn_i        (spi_csn),
    .mosi_i       (spi_mosi),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  dds_reg_bank #(
    .PHASE_W (PHASE_W)
  ) u_bank (
    .clk          (clk),
    .rst          (rst),
    .word_valid_i (word_valid),
    .word_i       (word),
    .freq_q       (freq_q),
    .phase_q      (phase_q),
    .ctrl_q       (ctrl_q)
  );

  dds_sel_mux #(
    .PHASE_W     (PHASE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mux (
    .clk            (clk),
    .rst            (rst),
    .ctrl_i         (ctrl_q),
    .ext_fsel_i     (ext_fsel),
    .ext_psel_i     (ext_psel),
    .freq_i         (freq_q),
    .phase_i        (phase_q),
    .fsel_o         (fsel_o),
    .psel_o         (psel_o),
    .active_freq_o  (active_freq_o),
    .active_phase_o (active_phase_o)
  );

  for (genvar f = 0; f < N_FREQ; f++) begin : g_freq_out
    assign freq_words_o[f*FREQ_W +: FREQ_W] = freq_q[f];
  end
  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase_out
    assign phase_words_o[p*PHASE_W +: PHASE_W] = phase_q[p];
  end

  assign sync_o   = ctrl_q.sync;
  assign selsrc_o = ctrl_q.selsrc;
  assign sleep_o  = ctrl_q.sleep;
  assign reset_o  = ctrl_q.core_rst;
  assign clear_o  = ctrl_q.clr;

  // R8: power flags change only on an accepted word
  p_power_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> $stable({sleep_o, reset_o, clear_o}));

endmodule

// File: tb/test_dds_cmd_port.sv
module test_dds_cmd_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        ext_fsel = 1'b0;
  logic [1:0]  ext_psel = 2'd0;
  logic [63:0] freq_words_o;
  logic [47:0] phase_words_o;
  logic        fsel_o;
  logic [1:0]  psel_o;
  logic [31:0] active_freq_o;
  logic [11:0] active_phase_o;
  logic        sync_o, selsrc_o, sleep_o, reset_o, clear_o;

  always #2 clk = ~clk;

  dds_cmd_port i_dds_cmd_port (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .ext_fsel(ext_fsel), .ext_psel(ext_psel), .freq_words_o(freq_words_o),
    .phase_words_o(phase_words_o), .fsel_o(fsel_o), .psel_o(psel_o),
    .active_freq_o(active_freq_o), .active_phase_o(active_phase_o), .sync_o(sync_o),
    .selsrc_o(selsrc_o), .sleep_o(sleep_o), .reset_o(reset_o), .clear_o(clear_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_freq [2];
  logic [11:0] m_ph   [4];
  logic [7:0]  m_hold;
  logic        m_fsel, m_sync, m_src, m_sleep, m_rst, m_clr;
  logic [1:0]  m_psel;

  task automatic model_reset();
    for (int i = 0; i < 2; i++) m_freq[i] = '0;
    for (int i = 0; i < 4; i++) m_ph[i] = '0;
    m_hold = '0; m_fsel = 0; m_psel = 0; m_sync = 0; m_src = 0;
    m_sleep = 1; m_rst = 1; m_clr = 1;
  endtask

  task automatic model_apply(input logic [15:0] w);
    logic [3:0] c; logic [3:0] a; logic [7:0] d;
    c = w[15:12]; a = w[11:8]; d = w[7:0];
    if (c == 4'h1 || c == 4'h3) m_hold = d;
    else if (c == 4'h2) begin
      if (!a[3]) m_freq[a[2]][a[1]*16 +: 16] = {m_hold, d};
    end else if (c == 4'h0) begin
      if (a[3]) m_ph[a[2:1]] = {m_hold[3:0], d};
    end else if (c[3:1] == 3'b011) begin
      m_fsel = w[11]; m_psel = w[10:9];
    end else if (c[3:2] == 2'b10) begin
      m_sync = w[13]; m_src = w[12];
    end else if (c[3:2] == 2'b11) begin
      m_sleep = w[13]; m_rst = w[12]; m_clr = w[11];
    end
  endtask

  function automatic logic eff_f();
    return m_src ? ext_fsel : m_fsel;
  endfunction
  function automatic logic [1:0] eff_p();
    return m_src ? ext_psel : m_psel;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    spi_csn = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = w[i];
      tick(4);
      spi_sclk = 1'b1;
      tick(4);
      spi_sclk = 1'b0;
    end
    tick(4);
    spi_csn = 1'b1;
    tick(12);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bits({16'h0, w}, 16);
    model_apply(w);
  endtask

  task automatic check_all(input string req);
    logic [63:0] ef; logic [47:0] ep; logic [31:0] eaf; logic [11:0] eap;
    logic [6:0] eflags, aflags;
    ef  = {m_freq[1], m_freq[0]};
    ep  = {m_ph[3], m_ph[2], m_ph[1], m_ph[0]};
    eaf = m_freq[eff_f()];
    eap = m_ph[eff_p()];
    eflags = {eff_f(), eff_p(), m_sync, m_src, m_sleep, m_rst, m_clr} ;
    aflags = {fsel_o, psel_o, sync_o, selsrc_o, sleep_o, reset_o, clear_o};
    checks++;
    if (freq_words_o !== ef || phase_words_o !== ep || active_freq_o !== eaf ||
        active_phase_o !== eap || aflags !== eflags) begin
      errors++;
      $display("FAIL %s freq act %h exp %h phase act %h exp %h afreq act %h exp %h aph act %h exp %h flags act %b exp %b",
               req, freq_words_o, ef, phase_words_o, ep, active_freq_o, eaf,
               active_phase_o, eap, aflags, eflags);
    end
  endtask

  task automatic load_freq(input int idx, input logic [31:0] v);
    logic [3:0] top;
    top = 4'(idx * 4 + 3);
    send_word({4'h3, top,        v[31:24]});
    send_word({4'h2, top - 4'd1, v[23:16]});
    send_word({4'h3, top - 4'd2, v[15:8]});
    send_word({4'h2, top - 4'd3, v[7:0]});
  endtask

  task automatic load_phase(input int idx, input logic [11:0] v);
    logic [3:0] hi;
    hi = 4'(8 + idx * 2 + 1);
    send_word({4'h1, hi,        4'h0, v[11:8]});
    send_word({4'h0, hi - 4'd1, v[7:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_2024);
    model_reset();
    tick(6);
    rst = 1'b0;
    tick(4);
    check_all("R1 reset state");

    // R3 frequency loads, R4 phase loads
    load_freq(0, 32'h1234_5678);
    check_all("R3 freq0 load");
    load_freq(1, 32'hDEAD_BEEF);
    check_all("R3 freq1 load");
    for (int p = 0; p < 4; p++) load_phase(p, 12'hA50 + 12'(p * 17));
    check_all("R4 phase loads");
    load_phase(2, 12'hFFF);
    check_all("R4 phase full scale");

    // R5 misaddressed commits
    send_word(16'h3_0_77);
    send_word(16'h2_9_55);
    check_all("R5 freq commit in phase half");
    send_word(16'h0_2_66);
    check_all("R5 phase commit in freq half");

    // R2 bad frame lengths, a power word that would clear flags
    send_bits(32'h0000_C000 >> 4, 12);
    check_all("R2 short frame 12");
    send_bits(32'h0000_C000 >> 1, 15);
    check_all("R2 short frame 15");
    send_bits(32'h0000_C000 << 1, 17);
    check_all("R2 long frame 17");
    send_bits(32'h0000_C000 << 2, 18);
    check_all("R2 long frame 18");

    // R8 power family across its codes
    send_word(16'hC000);
    check_all("R8 power all clear");
    send_word(16'hE800);
    check_all("R8 sleep and clear via 0xE");
    send_word(16'hD000);
    check_all("R8 reset via 0xD");

    // R6 selection, R11 active words
    send_word(16'h6A00);
    check_all("R6 select f1 p1 R11");
    send_word(16'h7600);
    check_all("R6 code 0x7 select R11");

    // R9 unused codes
    send_word(16'h4FFF);
    send_word(16'h5ABC);
    check_all("R9 codes 4 and 5 ignored");

    // R7 sync/source family, R10 external pins
    send_word(16'hA000);
    check_all("R7 sync via 0xA");
    ext_fsel = 1'b0; ext_psel = 2'd3;
    tick(8);
    check_all("R10 serial source ignores pins");
    send_word(16'h9000);
    check_all("R7 selsrc via 0x9 R10");
    ext_fsel = 1'b1; ext_psel = 2'd1;
    tick(8);
    check_all("R10 pins drive selection R11");
    send_word(16'h8000);
    check_all("R7 back to serial R10");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] w; logic [3:0] c; int r;
      r = $urandom % 16;
      case (r % 8)
        0, 1: c = 4'h3;
        2, 3: c = 4'h2;
        4:    c = 4'h1;
        5:    c = 4'h0;
        default: c = 4'($urandom);
      endcase
      w = {c, 12'($urandom)};
      if (($urandom % 8) == 0) begin
        ext_fsel = 1'($urandom); ext_psel = 2'($urandom);
      end
      if (r == 15) send_bits({16'h0, w} << 1, 17);
      else if (r == 14) send_bits({16'h0, w} >> 3, 13);
      else send_word(w);
      check_all((r >= 14) ? "R2 random bad frame" : "R3 R4 R6 R7 R8 R10 random word");
    end

    // R1 reset again after activity
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    ext_fsel = 1'b0; ext_psel = 2'd0;
    model_reset();
    tick(6);
    check_all("R1 reset after traffic");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule